// File: doc/BRIEF.md
# Two-Slot Relay Station

A pipeline stage for long point-to-point links that follow a latency-insensitive protocol. Every cycle the link carries one beat: either a data word with its valid flag raised, or a void token with the flag low. The station registers each beat and presents it downstream one cycle later. A void token is not stored. It shows up at the output only as the absence of valid data.

Back-pressure arrives on a stop input from the downstream side. The station re-registers that stop before sending it upstream, so the upstream sender learns of a stall one cycle late. It can therefore launch one more word into a station whose output is already frozen. A second storage slot catches that word. The stop sent upstream is high exactly while both slots are full, so no word is ever overwritten, lost or delivered twice.

Top module: `relay_station2`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` and `in_stop` are 0, and both slots are empty.
- R2: A valid word taken from upstream (`in_valid`=1 while `in_stop`=0) by an empty station appears on `out_data` with `out_valid`=1 in the next cycle.
- R3: While `out_valid`=1 and `out_stop`=1, the next cycle still shows `out_valid`=1 with an unchanged `out_data`.
- R4: `in_stop` is a registered output. It rises only in the cycle after a valid word was taken while the output was stalled, and it stays high while both slots hold a word.
- R5: A word that upstream presents while `in_stop`=1 is not taken. The same word presented again later is delivered once.
- R6: Valid words leave in the order they were taken, each exactly once, under any pattern of `out_stop`.
- R7: A void token that arrives while the output is stalled is dropped. It does not fill the second slot (`in_stop` stays 0), and once the held word leaves, the output is void.
- R8: A void token entering an empty station, or one whose held word leaves, gives a void output (`out_valid`=0) in the next cycle.
- R9: When both slots are full and `out_stop` is 0, the second word moves to the output in the next cycle and `in_stop` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream beat carries valid data |
| in_data | input | W | Upstream data word |
| in_stop | output | 1 | Registered back-pressure to upstream |
| out_valid | output | 1 | Downstream beat carries valid data |
| out_data | output | W | Downstream data word |
| out_stop | input | 1 | Back-pressure from downstream |

## Verification
The hardest state to reach is a full station whose second slot drains at the same edge where upstream is still showing a held word. That word must be neither taken early nor lost. Directed steps build it on purpose: stop is raised while a word is in flight, and the held word stays on the input while stop is released. Random phases with heavy, light and bursty stop patterns then enter and leave that state many times against a queue of expected words.

// File: rtl/relay_station2.sv
module relay_station2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_stop,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_stop
);

  logic         main_v, aux_v;
  logic [W-1:0] main_d, aux_d;
  logic         take, drain;

  assign take      = in_valid & ~in_stop;
  assign drain     = main_v & ~out_stop;
  assign out_valid = main_v;
  assign out_data  = main_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_v  <= 1'b0;
      aux_v   <= 1'b0;
      main_d  <= '0;
      aux_d   <= '0;
      in_stop <= 1'b0;
    end else if (aux_v) begin
      if (drain) begin
        main_d  <= aux_d;
        aux_v   <= 1'b0;
        in_stop <= 1'b0;
      end
    end else if (!main_v || drain) begin
      main_v <= take;
      if (take) main_d <= in_data;
    end else if (take) begin
      aux_v   <= 1'b1;
      aux_d   <= in_data;
      in_stop <= 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !in_stop);

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && in_valid && !in_stop |=> out_valid && out_data == $past(in_data));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stop |=> out_valid && $stable(out_data));

  assert_stop_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_stop) |-> $past(out_valid && out_stop && in_valid));

  assert_stop_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop && out_stop |=> in_stop);

  assert_void_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stop && !in_valid && (!out_valid || !out_stop) |=> !out_valid);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop && !out_stop |=> !in_stop && out_valid);

endmodule

// File: tb/relay_station2_tb.sv
`timescale 1ns/1ps
module relay_station2_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, out_stop;
  logic [W-1:0] in_data;
  logic         in_stop, out_valid;
  logic [W-1:0] out_data;

  int           checks = 0, fails = 0;
  logic [W-1:0] q[$];
  logic         pend = 1'b0;
  logic [W-1:0] seq = 32'h1000;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  relay_station2 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_stop(in_stop),
    .out_valid(out_valid), .out_data(out_data), .out_stop(out_stop)
  );

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drv(logic v, logic [W-1:0] d, logic s);
    in_valid = v; in_data = d; out_stop = s;
    @(negedge clk);
  endtask

  task automatic run_phase(int n, int vpct, int spct);
    logic [W-1:0] exp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      out_stop = ($urandom_range(99) < spct);
      if (out_valid && !out_stop) begin
        if (q.size() == 0) chk(1'b0, "R6 extra word", out_data, '0);
        else begin
          exp = q.pop_front();
          chk(out_data == exp, "R6 order", out_data, exp);
        end
      end
      if (!pend) begin
        in_valid = ($urandom_range(99) < vpct);
        in_data  = in_valid ? seq : $urandom;
        if (in_valid) seq++;
      end
      if (in_valid && !in_stop) begin
        q.push_back(in_data);
        pend = 1'b0;
      end else pend = in_valid;   // R5: held word retried, void dropped
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_stop, "R1 in reset", {out_valid, in_stop}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_stop, "R1 after reset", {out_valid, in_stop}, '0);

    drv(1'b1, 32'hA1, 1'b0);
    chk(out_valid && out_data == 32'hA1, "R2", out_data, 32'hA1);
    drv(1'b1, 32'hA2, 1'b1);
    chk(out_valid && out_data == 32'hA1, "R3", out_data, 32'hA1);
    chk(in_stop, "R4 rise", in_stop, 1);
    drv(1'b1, 32'hA3, 1'b1);
    chk(in_stop && out_data == 32'hA1, "R4 hold", {in_stop, out_data[7:0]}, {1'b1, 8'hA1});
    drv(1'b1, 32'hA3, 1'b0);
    chk(out_valid && out_data == 32'hA2, "R9 aux moves", out_data, 32'hA2);
    chk(!in_stop, "R9 stop falls", in_stop, 0);
    drv(1'b1, 32'hA3, 1'b0);
    chk(out_valid && out_data == 32'hA3, "R5 held word once", out_data, 32'hA3);
    drv(1'b0, 32'hFF, 1'b0);
    chk(!out_valid, "R8 void passes", out_valid, 0);
    drv(1'b1, 32'hB1, 1'b0);
    chk(out_data == 32'hB1, "R2 second", out_data, 32'hB1);
    drv(1'b0, 32'hEE, 1'b1);
    chk(!in_stop && out_data == 32'hB1, "R7 void not stored", in_stop, 0);
    drv(1'b0, 32'hEE, 1'b0);
    chk(!out_valid, "R7 void after drain", out_valid, 0);

    in_valid = 1'b0; out_stop = 1'b0;
    run_phase(3000, 90, 10);
    run_phase(3000, 50, 50);
    run_phase(3000, 100, 70);
    run_phase(2000, 100, 0);
    for (int b = 0; b < 40; b++) begin
      run_phase(20, 100, 100);
      run_phase(15, 70, 0);
    end
    run_phase(40, 0, 0);
    chk(q.size() == 0, "R6 all delivered", q.size(), 0);
    chk(!in_stop && !out_valid, "R6 empty at end", {in_stop, out_valid}, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule